// File: doc/BRIEF.md
# Multifunction ALU with barrel shifter

The block is a purely combinational arithmetic/logic unit for a small load/store processor. It takes two operands, a constant shift amount and an 8-bit control word. It returns one result word, a zero flag and an overflow flag.

Inside, three units work side by side:

- an add/subtract unit built around a single adder;
- a bitwise logic unit;
- a barrel shifter with log2(WIDTH) stages, each stage moving the word by a power of two.

A final selector, driven by the function class field of the control word, picks which unit's output becomes the result. A signed set-less-than operation reuses the adder in subtract mode. It returns 0 or 1 and stays correct when the difference overflows.

A small decoder turns the control word into a struct of strobes. The datapath takes only that struct. Control word layout:

| Bits | Field |
|---|---|
| [7:6] | function class |
| [5] | subtract select |
| [4] | shift direction |
| [3] | shift type |
| [2] | shift amount source |
| [1:0] | logic function |

Top module: `alu_core`

## Requirements
- R1: With class ctrlWord[7:6]=10 and ctrlWord[5]=0, result is opA+opB modulo 2^WIDTH.
- R2: With class 10 and ctrlWord[5]=1, result is opA-opB modulo 2^WIDTH. The adder uses the bit-inverted opB with a carry-in of 1.
- R3: overflowFlag is 1 only in class 10, and only when the two's-complement sum or difference has a sign that is wrong for its operands. In classes 00, 01 and 11 it is 0.
- R4: zeroFlag is 1 exactly when result is all zeros, in every class.
- R5: With class 11, ctrlWord[1:0] selects the logic function: 00=AND, 01=OR, 10=XOR, 11=NOR of opA and opB.
- R6: With class 00 and ctrlWord[4]=0, result is opB shifted left by the amount, with zeros filling the vacated bits. ctrlWord[3] has no effect in this case.
- R7: With class 00, ctrlWord[4]=1 and ctrlWord[3]=0, result is opB shifted right logically, with zeros filling the vacated bits.
- R8: With class 00, ctrlWord[4]=1 and ctrlWord[3]=1, result is opB shifted right arithmetically, with copies of opB's sign bit filling the vacated bits.
- R9: The shift amount is shamtConst when ctrlWord[2]=0. When ctrlWord[2]=1 it is the low log2(WIDTH) bits of opA, and the upper bits of opA have no effect.
- R10: With class 01, result is 1 if opA < opB as signed numbers and 0 otherwise, including when opA-opB overflows. ctrlWord[5] has no effect in this class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand; low bits also give the variable shift amount |
| opB | input | WIDTH | Second operand; the word that is shifted |
| shamtConst | input | log2(WIDTH) | Constant shift amount |
| ctrlWord | input | 8 | Operation control word |
| result | output | WIDTH | Selected unit output |
| zeroFlag | output | 1 | Result is all zeros |
| overflowFlag | output | 1 | Signed add/subtract overflow |

## Verification
The bench builds the block with its default WIDTH of 32, which gives five shifter stages and a 32-bit adder. This brings within reach the corner cases that need a full-width word:

- the sign boundaries 0x7FFFFFFF and 0x80000000 for overflow and set-less-than;
- shift amounts of 0 and 31;
- variable shift amounts taken from operands whose bits above bit 4 are set.

Directed vectors for these cases are followed by a few hundred pseudo-random operand and control combinations. Each one is compared against an operator-level model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_SLT   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_LOGIC = 2'b11
  } aluClass_e;

  localparam logic [1:0] LOG_AND = 2'b00;
  localparam logic [1:0] LOG_OR  = 2'b01;
  localparam logic [1:0] LOG_XOR = 2'b10;
  localparam logic [1:0] LOG_NOR = 2'b11;

  typedef struct packed {
    logic       selShift;
    logic       selSlt;
    logic       selArith;
    logic       selLogic;
    logic       subtract;
    logic       shiftLeft;
    logic       shiftArith;
    logic       useVarAmt;
    logic [1:0] logicOp;
  } aluStrobes_t;

endpackage

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [7:0]  ctrlWord,
  output aluStrobes_t strobes
);

  aluClass_e opClass;

  always_comb begin
    opClass            = aluClass_e'(ctrlWord[7:6]);
    strobes.selShift   = (opClass == CLS_SHIFT);
    strobes.selSlt     = (opClass == CLS_SLT);
    strobes.selArith   = (opClass == CLS_ARITH);
    strobes.selLogic   = (opClass == CLS_LOGIC);
    // Compare always subtracts, whatever the subtract bit says (R10)
    strobes.subtract   = ctrlWord[5] | (opClass == CLS_SLT);
    strobes.shiftLeft  = ~ctrlWord[4];
    strobes.shiftArith = ctrlWord[4] & ctrlWord[3];
    strobes.useVarAmt  = ctrlWord[2];
    strobes.logicOp    = ctrlWord[1:0];
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter  int WIDTH = 32,
  localparam int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] shiftIn,
  input  logic [SHW-1:0]   shiftAmt,
  input  logic             shiftLeft,
  input  logic             shiftArith,
  output logic [WIDTH-1:0] shiftOut
);

  logic             fillBit;
  logic [WIDTH-1:0] stageVal [0:SHW];

  assign fillBit     = shiftArith & shiftIn[WIDTH-1];
  assign stageVal[0] = shiftIn;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stageVal[k+1] =
      !shiftAmt[k] ? stageVal[k] :
      shiftLeft    ? {stageVal[k][WIDTH-1-DIST:0], {DIST{1'b0}}} :
                     {{DIST{fillBit}}, stageVal[k][WIDTH-1:DIST]};
  end

  assign shiftOut = stageVal[SHW];

  always_comb begin
    // R6: an amount of zero passes the word through unchanged
    p_shift_noop_r6: assert (shiftAmt != '0 || shiftOut == shiftIn)
      else $error("shift by zero altered the word");
    // R8: an arithmetic right shift keeps the sign bit
    p_sra_sign_r8: assert (!(shiftArith && !shiftLeft) ||
                           shiftOut[WIDTH-1] == shiftIn[WIDTH-1])
      else $error("arithmetic shift lost the sign");
    // R7: a logical right shift by a nonzero amount clears the top bit
    p_srl_msb_r7: assert (shiftLeft || shiftArith || shiftAmt == '0 ||
                          !shiftOut[WIDTH-1])
      else $error("logical right shift filled with one");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter  int WIDTH = 32,
  localparam int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamtConst,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflowFlag
);

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-2:0] lowSum;
  logic             carryOut;
  logic             carryMsb;
  logic             ovfRaw;
  logic             lessThan;
  logic [WIDTH-1:0] logicVal;
  logic [WIDTH-1:0] shiftVal;
  logic [SHW-1:0]   shiftAmt;

  // Single adder for add, subtract and compare
  assign bEff = strobes.subtract ? ~opB : opB;
  assign {carryOut, sumVal} = {1'b0, opA} + {1'b0, bEff}
                            + {{WIDTH{1'b0}}, strobes.subtract};
  assign {carryMsb, lowSum} = {1'b0, opA[WIDTH-2:0]} + {1'b0, bEff[WIDTH-2:0]}
                            + {{(WIDTH-1){1'b0}}, strobes.subtract};
  assign ovfRaw   = carryMsb ^ carryOut;
  assign lessThan = sumVal[WIDTH-1] ^ ovfRaw;

  // Bitwise logic unit
  always_comb begin
    unique case (strobes.logicOp)
      LOG_AND: logicVal = opA & opB;
      LOG_OR:  logicVal = opA | opB;
      LOG_XOR: logicVal = opA ^ opB;
      default: logicVal = ~(opA | opB);
    endcase
  end

  // Barrel shifter
  assign shiftAmt = strobes.useVarAmt ? opA[SHW-1:0] : shamtConst;

  alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .shiftIn   (opB),
    .shiftAmt  (shiftAmt),
    .shiftLeft (strobes.shiftLeft),
    .shiftArith(strobes.shiftArith),
    .shiftOut  (shiftVal)
  );

  // Final selector
  always_comb begin
    unique case (1'b1)
      strobes.selShift: result = shiftVal;
      strobes.selSlt:   result = {{(WIDTH-1){1'b0}}, lessThan};
      strobes.selArith: result = sumVal;
      default:          result = logicVal;
    endcase
    zeroFlag     = (result == '0);
    overflowFlag = strobes.selArith & ovfRaw;
  end

  always_comb begin
    // R10: a compare yields only 0 or 1
    p_slt_binary_r10: assert (!strobes.selSlt || result[WIDTH-1:1] == '0)
      else $error("compare result wider than one bit");
    // R2: in subtract mode, the difference plus opB gives back opA
    p_sub_inverse_r2: assert (!(strobes.selArith && strobes.subtract) ||
                              (sumVal + opB) == opA)
      else $error("difference does not restore opA");
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter  int WIDTH = 32,
  localparam int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamtConst,
  input  logic [7:0]       ctrlWord,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflowFlag
);

  aluStrobes_t strobes;

  alu_control u_control (
    .ctrlWord(ctrlWord),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA         (opA),
    .opB         (opB),
    .shamtConst  (shamtConst),
    .strobes     (strobes),
    .result      (result),
    .zeroFlag    (zeroFlag),
    .overflowFlag(overflowFlag)
  );

  always_comb begin
    // R3: the overflow flag is raised only in the arithmetic class
    p_ovf_class_r3: assert (!overflowFlag || strobes.selArith)
      else $error("overflow outside arithmetic class");
  end

endmodule

// File: tb/alu_core_bench.sv
module alu_core_bench;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         zf;
    logic         vf;
    string        tag;
  } expItem_t;

  logic         clk = 0;
  logic         rstN = 0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [4:0]   shamtConst = '0;
  logic [7:0]   ctrlWord = '0;
  logic [W-1:0] result;
  logic         zeroFlag;
  logic         overflowFlag;

  int checks = 0;
  int errors = 0;
  expItem_t scoreQ[$];

  always #10 clk = ~clk;

  alu_core u_alu_core (
    .opA(opA), .opB(opB), .shamtConst(shamtConst), .ctrlWord(ctrlWord),
    .result(result), .zeroFlag(zeroFlag), .overflowFlag(overflowFlag)
  );

  function automatic expItem_t model(logic [W-1:0] a, logic [W-1:0] b,
                                     logic [4:0] sh, logic [7:0] c, string tag);
    expItem_t e;
    logic [4:0] amt;
    e.vf  = 1'b0;
    e.tag = tag;
    amt   = c[2] ? a[4:0] : sh;                           // R9
    case (c[7:6])
      2'b00: begin
        if (!c[4])     e.res = b << amt;                  // R6
        else if (c[3]) e.res = W'($signed(b) >>> amt);    // R8
        else           e.res = b >> amt;                  // R7
      end
      2'b01: e.res = ($signed(a) < $signed(b)) ? 1 : 0;   // R10
      2'b10: begin
        if (c[5]) begin                                   // R2
          e.res = a - b;
          e.vf  = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
        end else begin                                    // R1
          e.res = a + b;
          e.vf  = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
        end
      end
      default: case (c[1:0])                              // R5
        2'b00: e.res = a & b;
        2'b01: e.res = a | b;
        2'b10: e.res = a ^ b;
        default: e.res = ~(a | b);
      endcase
    endcase
    e.zf = (e.res == '0);                                 // R4
    return e;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [4:0] sh,
                       logic [7:0] c, string tag);
    @(posedge clk);
    opA = a; opB = b; shamtConst = sh; ctrlWord = c;
    scoreQ.push_back(model(a, b, sh, c, tag));
  endtask

  // Monitor: compares the oldest pending item at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        checks++;
        if (result !== e.res) begin
          errors++;
          $display("FAIL %s result got %h exp %h", e.tag, result, e.res);
        end
        checks++;
        if (zeroFlag !== e.zf) begin
          errors++;
          $display("FAIL %s R4 zeroFlag got %b exp %b", e.tag, zeroFlag, e.zf);
        end
        checks++;
        if (overflowFlag !== e.vf) begin
          errors++;
          $display("FAIL %s R3 overflowFlag got %b exp %b", e.tag, overflowFlag, e.vf);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge rstN);
    // Idle inputs: shift of zero by zero gives zero result and zero flag
    drive(0, 0, 0, 8'h00, "R4 idle");
    // R1 add, including overflow and wrap to zero
    drive(32'd5, 32'd7, 0, 8'b10_0_000_00, "R1 add");
    drive(32'h7FFF_FFFF, 32'd1, 0, 8'b10_0_000_00, "R1 R3 add ovf");
    drive(32'hFFFF_FFFF, 32'd1, 0, 8'b10_0_000_00, "R1 R4 wrap zero");
    drive(32'h8000_0000, 32'h8000_0000, 0, 8'b10_0_111_11, "R1 R3 neg ovf");
    // R2 subtract
    drive(32'd9, 32'd9, 0, 8'b10_1_000_00, "R2 sub zero");
    drive(32'h8000_0000, 32'd1, 0, 8'b10_1_000_00, "R2 R3 sub ovf");
    drive(32'd3, 32'd10, 0, 8'b10_1_000_00, "R2 sub neg");
    // R5 logic functions
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 0, 8'b11_0_000_00, "R5 and");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 0, 8'b11_0_000_01, "R5 or");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 0, 8'b11_0_000_10, "R5 xor");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 0, 8'b11_0_000_11, "R5 nor");
    drive(32'hFFFF_FFFF, 32'h0, 0, 8'b11_1_000_11, "R5 R3 nor zero");
    // R6/R7/R8 shifts by constant
    drive(0, 32'h8000_0001, 5'd0,  8'b00_0_000_00, "R6 shl zero amt");
    drive(0, 32'h8000_0001, 5'd31, 8'b00_0_000_00, "R6 shl 31");
    drive(0, 32'h8000_0001, 5'd4,  8'b00_0_010_00, "R6 shl type ignored");
    drive(0, 32'h8000_0000, 5'd31, 8'b00_0_100_00, "R7 srl 31");
    drive(0, 32'h8765_4321, 5'd13, 8'b00_0_100_00, "R7 srl 13");
    drive(0, 32'h8765_4321, 5'd13, 8'b00_0_110_00, "R8 sra 13");
    drive(0, 32'h8000_0000, 5'd31, 8'b00_0_110_00, "R8 sra 31");
    drive(0, 32'h4000_0000, 5'd30, 8'b00_0_110_00, "R8 sra positive");
    // R9 variable amount, upper bits of opA ignored
    drive(32'hFFFF_FFE3, 32'h0000_00FF, 5'd1, 8'b00_0_001_00, "R9 var shl");
    drive(32'h1234_5620, 32'hDEAD_BEEF, 5'd7, 8'b00_0_111_00, "R9 var sra zero");
    drive(32'hABCD_EF08, 32'hDEAD_BEEF, 5'd0, 8'b00_0_101_00, "R9 var srl");
    // R10 signed compare, including overflowing differences
    drive(32'h8000_0000, 32'd1, 0, 8'b01_0_000_00, "R10 slt ovf true");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 0, 8'b01_0_000_00, "R10 slt ovf false");
    drive(32'd4, 32'd4, 0, 8'b01_1_000_00, "R10 slt equal");
    drive(32'hFFFF_FFFF, 32'd0, 0, 8'b01_0_000_00, "R10 slt neg");
    // Pseudo-random sweep
    for (int i = 0; i < 400; i++) begin
      drive($urandom(), $urandom(), 5'($urandom()), 8'($urandom()), "R1 R5 R6 R10 random");
    end
    while (scoreQ.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule